// File: doc/BRIEF.md
# Three-Tap Vertical Flicker Filter

This block turns a progressive 4:4:4 YCbCr frame stream into an interlaced field stream. Every input frame yields one output field, and successive frames alternate between the odd field and the even field. Each output line is a vertical low-pass of three adjacent input lines in the same column, weighted one quarter, one half and one quarter. This softens detail that is one line tall and would otherwise flicker on an interlaced display. Two input lines arrive for every output line, so the filter keeps one output line for each pair of input lines.

Two line stores hold the two most recent input lines. An output pixel comes out one clock after the input pixel that completes its three-line window. At the top and bottom of a frame, a missing neighbour line is replaced by the centre line. The centre then carries three quarters of the weight.

An enable input is taken at each frame start. With the filter off, the block copies its input to its output through the same single register stage, so the timing seen downstream does not change.

Top module: `vflick_filter`

## Requirements
- R1: For an interior centre line c, each 8-bit output component equals (a + 2b + d + 2) >> 2, where a, b and d are the same column and component of input lines c-1, c and c+1 of the current frame. The result never exceeds 255. Component k occupies bits [8k+7:8k] of the pixel buses.
- R2: The first frame after reset gives field flag 0 (odd), with centres on even input lines 0, 2, 4, and so on. The flag inverts at every frame start. Field 1 (even) centres on odd input lines. The flag does not change between frame starts.
- R3: When the centre is input line 0, the output is (3b + d + 2) >> 2.
- R4: When the centre is the last line of the frame (FRAME_LINES-1), the output is (a + 3b + 2) >> 2. It is emitted while that last line arrives.
- R5: For every other centre, the output pixel for centre c, column x appears on the clock after column x of line c+1 is accepted. No output is valid unless an input pixel was valid on the previous cycle.
- R6: o_sol marks column 0 of each output line. o_sof marks column 0 of the first output line of each field and is only set together with o_sol and o_valid.
- R7: The enable input is sampled only on the frame-start pixel and holds for the whole frame. When it is sampled low, every accepted input pixel, together with its sol and sof markers, appears unchanged one clock later, and the field flag still alternates.
- R8: Valid pixels that arrive before the first frame start after reset are ignored and produce no output.
- R9: During and right after reset, o_valid, o_sol, o_sof and o_field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_enable | input | 1 | Filter enable, taken at frame start |
| i_valid | input | 1 | Input pixel valid |
| i_sof | input | 1 | First pixel of a frame |
| i_sol | input | 1 | First pixel of a line |
| i_pix | input | 24 | Input pixel, three 8-bit components |
| o_valid | output | 1 | Output pixel valid |
| o_sof | output | 1 | First pixel of a field |
| o_sol | output | 1 | First pixel of an output line |
| o_field | output | 1 | Field flag, 0 odd, 1 even |
| o_pix | output | 24 | Output pixel, three 8-bit components |

## Verification
The assertions assume well-formed input framing:
- i_sof is raised only together with i_sol.
- Each line carries exactly LINE_PIX valid pixels.
- Each frame carries exactly FRAME_LINES lines.

The bench builds every frame from nested line and column loops, so this framing holds by construction. Idle cycles are inserted in the middle of some lines and stray pixels are sent before the first frame, without breaking the framing. The i_enable level is inverted after each frame-start pixel, so that sampling outside the frame start would be visible at the outputs.

// File: rtl/vff_pkg.sv
package vff_pkg;
  // Which vertical window a pixel completes
  typedef enum logic [1:0] {
    TAP_NONE = 2'd0,  // no output for this input pixel
    TAP_MID  = 2'd1,  // interior centre, lines c-1, c, c+1
    TAP_TOP  = 2'd2,  // centre is line 0, upper tap folded into centre
    TAP_BOT  = 2'd3   // centre is last line, lower tap folded into centre
  } tap_sel_e;
endpackage

// File: rtl/vff_line_tracker.sv
module vff_line_tracker
  import vff_pkg::*;
#(
  parameter int LINE_PIX    = 720,
  parameter int FRAME_LINES = 525
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          i_valid,
  input  logic                          i_sof,
  input  logic                          i_sol,
  input  logic                          i_enable,
  output logic                          accept,
  output logic                          sof_take,
  output logic [$clog2(LINE_PIX)-1:0]   x_now,
  output logic                          field_now,
  output logic                          field_q,
  output logic                          en_now,
  output logic                          first_out,
  output tap_sel_e                      sel
);
  localparam int XW = $clog2(LINE_PIX);
  localparam int LW = $clog2(FRAME_LINES);
  localparam logic [LW-1:0] LAST_LINE = LW'(FRAME_LINES - 1);

  logic          in_frame_q;
  logic          en_q;
  logic [LW-1:0] line_q;
  logic [XW-1:0] x_q;
  logic [LW-1:0] line_now;
  logic          centre_passed;
  logic          centre_is_last;

  assign sof_take  = i_valid && i_sof;
  assign accept    = i_valid && (in_frame_q || i_sof);
  // R2: parity flips at each frame start, reset value makes frame 0 odd
  assign field_now = sof_take ? ~field_q : field_q;
  // R7: enable only taken on the frame-start pixel
  assign en_now    = sof_take ? i_enable : en_q;

  always_comb begin
    if (i_sof)      line_now = '0;
    else if (i_sol) line_now = line_q + LW'(1);
    else            line_now = line_q;
    if (i_sof || i_sol) x_now = '0;
    else                x_now = x_q + XW'(1);
  end

  // centre line k-1 has the field's parity, so line k closes its window
  assign centre_passed  = (line_now != '0) && (line_now[0] != field_now);
  // the last line is itself a centre of this field
  assign centre_is_last = (line_now == LAST_LINE) && (line_now[0] == field_now);

  always_comb begin
    sel = TAP_NONE;
    if (accept) begin
      if (centre_passed)       sel = (line_now == LW'(1)) ? TAP_TOP : TAP_MID;
      else if (centre_is_last) sel = TAP_BOT;
    end
  end

  // first output line of a field: centre 0 (odd) closes on line 1, centre 1 (even) on line 2
  assign first_out = (line_now == (field_now ? LW'(2) : LW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      en_q       <= 1'b0;
      field_q    <= 1'b1;
      line_q     <= '0;
      x_q        <= '0;
    end else if (accept) begin
      in_frame_q <= 1'b1;
      en_q       <= en_now;
      field_q    <= field_now;
      line_q     <= line_now;
      x_q        <= x_now;
    end
  end
endmodule

// File: rtl/vff_line_store.sv
module vff_line_store #(
  parameter int LINE_PIX = 720,
  parameter int PIX_W    = 24
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [$clog2(LINE_PIX)-1:0] addr,
  input  logic [PIX_W-1:0]            din,
  output logic [PIX_W-1:0]            prev1,
  output logic [PIX_W-1:0]            prev2
);
  // prev1: same column one line up, prev2: two lines up
  logic [PIX_W-1:0] near_q [LINE_PIX];
  logic [PIX_W-1:0] far_q  [LINE_PIX];

  assign prev1 = near_q[addr];
  assign prev2 = far_q[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      far_q[addr]  <= near_q[addr];
      near_q[addr] <= din;
    end
  end
endmodule

// File: rtl/vff_tap_math.sv
module vff_tap_math
  import vff_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int N_COMP = 3
) (
  input  tap_sel_e                   sel,
  input  logic [COMP_W*N_COMP-1:0]   up2,
  input  logic [COMP_W*N_COMP-1:0]   up1,
  input  logic [COMP_W*N_COMP-1:0]   cur,
  output logic [COMP_W*N_COMP-1:0]   res
);
  localparam int SUM_W = COMP_W + 2;

  // R1: quarter-half-quarter with rounding; sum width holds 4*max+2
  function automatic logic [COMP_W-1:0] tap3(input logic [COMP_W-1:0] a,
                                              input logic [COMP_W-1:0] b,
                                              input logic [COMP_W-1:0] d);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + (SUM_W'(b) << 1) + SUM_W'(d) + SUM_W'(2);
    return s[SUM_W-1:2];
  endfunction

  for (genvar k = 0; k < N_COMP; k++) begin : g_comp
    logic [COMP_W-1:0] ta, tb, td;
    always_comb begin
      unique case (sel)
        TAP_TOP: begin ta = up1[k*COMP_W +: COMP_W]; tb = up1[k*COMP_W +: COMP_W]; td = cur[k*COMP_W +: COMP_W]; end // R3
        TAP_BOT: begin ta = up1[k*COMP_W +: COMP_W]; tb = cur[k*COMP_W +: COMP_W]; td = cur[k*COMP_W +: COMP_W]; end // R4
        default: begin ta = up2[k*COMP_W +: COMP_W]; tb = up1[k*COMP_W +: COMP_W]; td = cur[k*COMP_W +: COMP_W]; end
      endcase
    end
    assign res[k*COMP_W +: COMP_W] = tap3(ta, tb, td);
  end
endmodule

// File: rtl/vflick_filter.sv
module vflick_filter
  import vff_pkg::*;
#(
  parameter int COMP_W      = 8,
  parameter int N_COMP      = 3,
  parameter int LINE_PIX    = 720,
  parameter int FRAME_LINES = 525
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     i_enable,
  input  logic                     i_valid,
  input  logic                     i_sof,
  input  logic                     i_sol,
  input  logic [COMP_W*N_COMP-1:0] i_pix,
  output logic                     o_valid,
  output logic                     o_sof,
  output logic                     o_sol,
  output logic                     o_field,
  output logic [COMP_W*N_COMP-1:0] o_pix
);
  localparam int PIX_W = COMP_W * N_COMP;
  localparam int XW    = $clog2(LINE_PIX);

  logic             accept, sof_take, field_now, field_q, en_now, first_out;
  logic [XW-1:0]    x_now;
  tap_sel_e         sel;
  logic [PIX_W-1:0] up1_pix, up2_pix, filt_pix;
  logic             emit;

  vff_line_tracker #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_track (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sof(i_sof), .i_sol(i_sol),
    .i_enable(i_enable), .accept(accept), .sof_take(sof_take), .x_now(x_now),
    .field_now(field_now), .field_q(field_q), .en_now(en_now),
    .first_out(first_out), .sel(sel)
  );

  vff_line_store #(.LINE_PIX(LINE_PIX), .PIX_W(PIX_W)) u_store (
    .clk(clk), .wr_en(accept), .addr(x_now), .din(i_pix),
    .prev1(up1_pix), .prev2(up2_pix)
  );

  vff_tap_math #(.COMP_W(COMP_W), .N_COMP(N_COMP)) u_math (
    .sel(sel), .up2(up2_pix), .up1(up1_pix), .cur(i_pix), .res(filt_pix)
  );

  assign emit = (sel != TAP_NONE);

  // single output register shared by both modes keeps latency matched (R7)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_sol   <= 1'b0;
      o_field <= 1'b0;
      o_pix   <= '0;
    end else begin
      if (en_now) begin
        o_valid <= emit;
        o_sol   <= emit && (x_now == '0);
        o_sof   <= emit && (x_now == '0) && first_out;
        o_pix   <= filt_pix;
      end else begin
        o_valid <= accept;
        o_sol   <= accept && i_sol;
        o_sof   <= accept && i_sof;
        o_pix   <= i_pix;
      end
      if (accept) o_field <= field_now;
    end
  end
endmodule

// File: rtl/vflick_filter_chk.sv
module vflick_filter_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i_valid,
  input logic [PIX_W-1:0] i_pix,
  input logic             o_valid,
  input logic             o_sof,
  input logic             o_sol,
  input logic [PIX_W-1:0] o_pix,
  input logic             accept,
  input logic             en_now,
  input logic             sof_take,
  input logic             field_q
);
  assert_out_needs_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(i_valid));

  assert_sof_with_sol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    o_sof |-> (o_sol && o_valid));

  assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !en_now) |=> (o_valid && o_pix == $past(i_pix)));

  assert_idle_no_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !o_valid);

  assert_field_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_take |=> $stable(field_q));
endmodule

bind vflick_filter vflick_filter_chk #(.PIX_W(PIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_pix(i_pix),
  .o_valid(o_valid), .o_sof(o_sof), .o_sol(o_sol), .o_pix(o_pix),
  .accept(accept), .en_now(en_now), .sof_take(sof_take), .field_q(field_q)
);

// File: tb/test_vflick_filter.sv
module test_vflick_filter;
  localparam int CW = 8;
  localparam int NC = 3;
  localparam int LP = 6;
  localparam int FL = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_enable = 1'b0, i_valid = 1'b0, i_sof = 1'b0, i_sol = 1'b0;
  logic [CW*NC-1:0] i_pix = '0;
  logic o_valid, o_sof, o_sol, o_field;
  logic [CW*NC-1:0] o_pix;

  always #4 clk = ~clk; // 125 MHz

  vflick_filter #(.COMP_W(CW), .N_COMP(NC), .LINE_PIX(LP), .FRAME_LINES(FL)) i_vflick_filter (
    .clk(clk), .rst_n(rst_n), .i_enable(i_enable), .i_valid(i_valid), .i_sof(i_sof),
    .i_sol(i_sol), .i_pix(i_pix), .o_valid(o_valid), .o_sof(o_sof), .o_sol(o_sol),
    .o_field(o_field), .o_pix(o_pix)
  );

  int n_run = 0, n_fail = 0, cycles = 0;

  // reference state
  int img [0:FL-1][0:LP-1][0:NC-1];
  bit in_fr = 0, rfield = 1, ren = 0;
  int rl = 0, rx = 0;
  bit e_v = 0, e_sol = 0, e_sof = 0, e_fld = 0;
  int e_pix [0:NC-1];
  string e_tag = "R8";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      report();
    end
  end

  task automatic compare();
    chk(o_valid == e_v, (e_v ? e_tag : "R8/R5 valid"), int'(o_valid), int'(e_v));
    if (e_v && o_valid) begin
      for (int k = 0; k < NC; k++)
        chk(int'(o_pix[k*CW +: CW]) == e_pix[k], e_tag, int'(o_pix[k*CW +: CW]), e_pix[k]);
      chk(o_sol == e_sol, "R6 sol", int'(o_sol), int'(e_sol));
      chk(o_sof == e_sof, "R6 sof", int'(o_sof), int'(e_sof));
      chk(o_field == e_fld, "R2 field", int'(o_field), int'(e_fld));
    end
  endtask

  task automatic model(input bit v, input bit sof, input bit sol, input bit en,
                       input logic [CW*NC-1:0] pix);
    int cu [0:NC-1];
    int c;
    e_v = 0; e_tag = "R8";
    if (!(v && (in_fr || sof))) return;
    if (sof) begin in_fr = 1; rfield = !rfield; ren = en; rl = 0; rx = 0; end
    else if (sol) begin rl++; rx = 0; end
    else rx++;
    for (int k = 0; k < NC; k++) cu[k] = int'(pix[k*CW +: CW]);
    e_fld = rfield;
    if (!ren) begin
      e_v = 1; e_sol = sol; e_sof = sof; e_tag = "R7";
      for (int k = 0; k < NC; k++) e_pix[k] = cu[k];
    end else if (rl >= 1 && ((rl - 1) % 2) == int'(rfield)) begin
      c = rl - 1;
      e_v = 1; e_sol = (rx == 0); e_sof = (rx == 0) && (c == int'(rfield));
      e_tag = (c == 0) ? "R3" : "R1/R5";
      for (int k = 0; k < NC; k++) begin
        int a = (c == 0) ? img[c][rx][k] : img[c-1][rx][k];
        e_pix[k] = (a + 2 * img[c][rx][k] + cu[k] + 2) / 4;
      end
    end else if (rl == FL - 1 && (rl % 2) == int'(rfield)) begin
      e_v = 1; e_sol = (rx == 0); e_sof = 0; e_tag = "R4";
      for (int k = 0; k < NC; k++)
        e_pix[k] = (img[rl-1][rx][k] + 3 * cu[k] + 2) / 4;
    end
    for (int k = 0; k < NC; k++) img[rl][rx][k] = cu[k];
  endtask

  task automatic cyc(input bit v, input bit sof, input bit sol, input bit en,
                     input logic [CW*NC-1:0] pix);
    @(negedge clk);
    compare();
    i_valid = v; i_sof = sof; i_sol = sol; i_enable = en; i_pix = pix;
    model(v, sof, sol, en, pix);
  endtask

  // mode 0 random, 1 all 255, 2 alternating 0/255 lines
  task automatic send_frame(input bit en, input int mode, input bit gaps);
    for (int l = 0; l < FL; l++)
      for (int x = 0; x < LP; x++) begin
        logic [CW*NC-1:0] p;
        bit first = (l == 0 && x == 0);
        if (gaps && x == 3) cyc(0, 0, 0, en, '0);
        case (mode)
          1: p = '1;
          2: p = (l % 2 == 1) ? '1 : '0;
          default: p = (CW*NC)'($urandom);
        endcase
        cyc(1, first, x == 0, first ? en : !en, p); // R7: level flips after sof
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(o_valid == 0, "R9", int'(o_valid), 0);
    chk(o_sol == 0 && o_sof == 0, "R9", int'({o_sol, o_sof}), 0);
    chk(o_field == 0, "R9", int'(o_field), 0);
    rst_n = 1'b1;
    // R8: stray pixels before any frame start
    cyc(1, 0, 1, 1, 24'h123456);
    cyc(1, 0, 0, 1, 24'hABCDEF);
    cyc(1, 0, 0, 0, 24'hFFFFFF);
    send_frame(1, 0, 0);   // odd field, R1 R3 R4
    send_frame(1, 0, 1);   // even field with idle gaps
    send_frame(0, 0, 0);   // bypass, R7
    send_frame(1, 1, 0);   // saturated input, no overflow, R1
    send_frame(1, 2, 1);   // alternating lines
    send_frame(1, 0, 0);
    send_frame(1, 2, 0);
    repeat (4) cyc(0, 0, 0, 0, '0);
    report();
  end
endmodule